// File: doc/BRIEF.md
# USB2 PHY Power-Up Sequencer

This block brings the analog front end of a USB2 PHY from a cold, isolated state to a running state without software involvement. After a `start` pulse it walks through a fixed list of control changes: isolation, low-leakage (IDDQ) mode, bandgap, LDO and PLL power-down releases, core-ready, the two power switches and the port-control field. Between each change it waits a fixed number of microsecond ticks. It then releases the PLL reset and the PHY reset and polls the PLL lock input once per tick.

If lock is not seen within `POLL_LIMIT` polls, the block pulses the PLL reset low for one clock and polls again. A second timeout raises `err`. Whether the lock phase succeeds or fails, the port-control field is then rewritten to the non-driving-low code and `done` pulses for one clock. Time is measured only in `us_tick` pulses, so the same netlist works at any clock rate. The one condition is that ticks arrive at least three clocks apart.

Top module: `usb2_phy_pwrseq`

## Requirements
- R1: After synchronous active-low reset, whether or not a sequence was running, every output is 0, including `port_ctl` = 2'b00, `iso`, `iddq`, `done` and `err`.
- R2: A `start` pulse in idle sets `iso` on the next clock edge and returns every other output to its reset value. `iddq` goes high on the 10th tick after that.
- R3: On tick 20, `port_ctl` takes `PCTL_UP` (default 2'b01). The bandgap, LDO and PLL power-down-bar outputs and `core_rdy` stay low until the later steps below.
- R4: `core_rdy` rises on tick 180. `bg_pwrdn_n` rises on tick 230.
- R5: `pwr_on_sw` and `ldo_pwrdn_n` rise together on tick 430. `pwr_ok_sw` rises on tick 440.
- R6: `pll_pwrdn_n` rises on tick 450, `iso` falls on tick 460 and `iddq` falls on tick 470.
- R7: `pll_rst_n` rises on tick 471, and `phy_rst_n` rises one clock later.
- R8: From tick 472, `pll_lock` is sampled only on tick cycles. A high sample ends the sequence with a single-clock `done`, `port_ctl` = `PCTL_NDL` (default 2'b10) and `err` low. A lock pulse between ticks has no effect.
- R9: If none of `POLL_LIMIT` (default 8) consecutive polls sees lock, `pll_rst_n` goes low for exactly one clock and a second window of `POLL_LIMIT` polls begins.
- R10: If the second window also times out, `err` rises together with `done` and `port_ctl` = `PCTL_NDL`. `err` holds until the next `start`.
- R11: A `start` pulse while a sequence is running has no effect on any output.
- R12: Lock seen on the last poll of a window counts as success. No PLL reset toggle and no error follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a power-up sequence (idle only) |
| us_tick | input | 1 | One-clock pulse every microsecond |
| pll_lock | input | 1 | PLL lock indication |
| iso | output | 1 | PHY isolation enable |
| iddq | output | 1 | PHY low-leakage mode enable |
| bg_pwrdn_n | output | 1 | Bandgap power-down, active low |
| ldo_pwrdn_n | output | 1 | LDO power-down, active low |
| pll_pwrdn_n | output | 1 | PLL power-down, active low |
| core_rdy | output | 1 | Core ready to PHY |
| pwr_on_sw | output | 1 | Power-on switch control |
| pwr_ok_sw | output | 1 | Power-good switch control |
| port_ctl | output | 2 | Port-control field |
| pll_rst_n | output | 1 | PLL reset, active low |
| phy_rst_n | output | 1 | PHY reset, active low |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Lock failed after retry |

## Verification
The lock detect and the poll timeout can both fall on the same tick, namely the final poll of a window. The bench provokes this by holding `pll_lock` low for seven polls and raising it exactly on the eighth. It judges the result by requiring `done` with `err` low and `pll_rst_n` still high on that same sample. A retry toggle or an error at that point would show the timeout path winning.

// File: rtl/usb2_phy_pwrseq.sv
module usb2_phy_pwrseq #(
  parameter int         POLL_LIMIT = 8,
  parameter logic [1:0] PCTL_UP    = 2'b01,
  parameter logic [1:0] PCTL_NDL   = 2'b10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       us_tick,
  input  logic       pll_lock,
  output logic       iso,
  output logic       iddq,
  output logic       bg_pwrdn_n,
  output logic       ldo_pwrdn_n,
  output logic       pll_pwrdn_n,
  output logic       core_rdy,
  output logic       pwr_on_sw,
  output logic       pwr_ok_sw,
  output logic [1:0] port_ctl,
  output logic       pll_rst_n,
  output logic       phy_rst_n,
  output logic       done,
  output logic       err
);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam int WW = 8;

  typedef enum logic [2:0] {IDLE, STEP, PLLUP, POLL, TOGGLE} st_t;

  st_t           st;
  logic [3:0]    step;
  logic [WW-1:0] wcnt;
  logic [PW-1:0] pcnt;
  logic          second;

  function automatic logic [WW-1:0] wait_of(input logic [3:0] s);
    case (s)
      4'd0, 4'd1: wait_of = WW'(10);
      4'd2:       wait_of = WW'(160);
      4'd3:       wait_of = WW'(50);
      4'd4:       wait_of = WW'(200);
      4'd9:       wait_of = WW'(1);
      default:    wait_of = WW'(10);
    endcase
  endfunction

  wire last_poll = (pcnt == PW'(POLL_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; step <= '0; wcnt <= '0; pcnt <= '0; second <= 1'b0;
      iso <= 1'b0; iddq <= 1'b0; bg_pwrdn_n <= 1'b0; ldo_pwrdn_n <= 1'b0;
      pll_pwrdn_n <= 1'b0; core_rdy <= 1'b0; pwr_on_sw <= 1'b0; pwr_ok_sw <= 1'b0;
      port_ctl <= 2'b00; pll_rst_n <= 1'b0; phy_rst_n <= 1'b0;
      done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          st <= STEP; step <= 4'd0; wcnt <= wait_of(4'd0);
          iso <= 1'b1; iddq <= 1'b0; bg_pwrdn_n <= 1'b0; ldo_pwrdn_n <= 1'b0;
          pll_pwrdn_n <= 1'b0; core_rdy <= 1'b0; pwr_on_sw <= 1'b0; pwr_ok_sw <= 1'b0;
          port_ctl <= 2'b00; pll_rst_n <= 1'b0; phy_rst_n <= 1'b0; err <= 1'b0;
        end
        STEP: if (us_tick) begin
          if (wcnt != WW'(1)) begin
            wcnt <= wcnt - 1'b1;
          end else if (step == 4'd9) begin
            pll_rst_n <= 1'b1;
            st <= PLLUP;
          end else begin
            step <= step + 1'b1;
            wcnt <= wait_of(step + 1'b1);
            case (step + 1'b1)
              4'd1: iddq <= 1'b1;
              4'd2: begin
                bg_pwrdn_n <= 1'b0; pll_pwrdn_n <= 1'b0; ldo_pwrdn_n <= 1'b0;
                core_rdy <= 1'b0; port_ctl <= PCTL_UP;
              end
              4'd3: core_rdy <= 1'b1;
              4'd4: bg_pwrdn_n <= 1'b1;
              4'd5: begin pwr_on_sw <= 1'b1; ldo_pwrdn_n <= 1'b1; end
              4'd6: pwr_ok_sw <= 1'b1;
              4'd7: pll_pwrdn_n <= 1'b1;
              4'd8: iso <= 1'b0;
              4'd9: iddq <= 1'b0;
              default: ;
            endcase
          end
        end
        PLLUP: begin
          phy_rst_n <= 1'b1;
          pcnt <= '0; second <= 1'b0;
          st <= POLL;
        end
        POLL: if (us_tick) begin
          if (pll_lock) begin
            port_ctl <= PCTL_NDL; done <= 1'b1; st <= IDLE;
          end else if (last_poll) begin
            if (second) begin
              port_ctl <= PCTL_NDL; done <= 1'b1; err <= 1'b1; st <= IDLE;
            end else begin
              pll_rst_n <= 1'b0; st <= TOGGLE;
            end
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        TOGGLE: begin
          pll_rst_n <= 1'b1; second <= 1'b1; pcnt <= '0; st <= POLL;
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  phy_after_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_rst_n) |-> pll_rst_n);

  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (done && port_ctl == PCTL_NDL));

  // R5
  ok_needs_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_ok_sw |-> pwr_on_sw);

  // R2
  iso_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iso) |-> $past(start));

  // R9
  toggle_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pll_rst_n) && phy_rst_n) |=> pll_rst_n);
endmodule

// File: tb/sim_usb2_phy_pwrseq.sv
module sim_usb2_phy_pwrseq;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, us_tick = 1'b0, pll_lock = 1'b0;
  logic iso, iddq, bg_pwrdn_n, ldo_pwrdn_n, pll_pwrdn_n, core_rdy;
  logic pwr_on_sw, pwr_ok_sw, pll_rst_n, phy_rst_n, done, err;
  logic [1:0] port_ctl;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  usb2_phy_pwrseq u0 (.clk(clk), .rst_n(rst_n), .start(start), .us_tick(us_tick),
    .pll_lock(pll_lock), .iso(iso), .iddq(iddq), .bg_pwrdn_n(bg_pwrdn_n),
    .ldo_pwrdn_n(ldo_pwrdn_n), .pll_pwrdn_n(pll_pwrdn_n), .core_rdy(core_rdy),
    .pwr_on_sw(pwr_on_sw), .pwr_ok_sw(pwr_ok_sw), .port_ctl(port_ctl),
    .pll_rst_n(pll_rst_n), .phy_rst_n(phy_rst_n), .done(done), .err(err));

  function automatic logic [13:0] act();
    return {iso, iddq, bg_pwrdn_n, ldo_pwrdn_n, pll_pwrdn_n, core_rdy,
            pwr_on_sw, pwr_ok_sw, port_ctl, pll_rst_n, phy_rst_n, done, err};
  endfunction

  function automatic logic [13:0] exp_at(input int n);
    return {n < 460, (n >= 10 && n < 470), n >= 230, n >= 430, n >= 450, n >= 180,
            n >= 430, n >= 440, (n >= 20) ? 2'b01 : 2'b00, n >= 471, 1'b0, 1'b0, 1'b0};
  endfunction

  function automatic string req_at(input int n);
    if (n < 20) return "R2";
    if (n < 180) return "R3";
    if (n < 430) return "R4";
    if (n < 450) return "R5";
    if (n < 471) return "R6";
    return "R7";
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, a, e, $time);
    end
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic tick();
    us_tick = 1'b1;
    @(negedge clk);
    us_tick = 1'b0;
  endtask

  task automatic run_to_poll();
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    chk(act() == exp_at(0), "R2", act(), exp_at(0));
    for (int n = 1; n <= 471; n++) begin
      tick();
      chk(act() == exp_at(n), req_at(n), act(), exp_at(n));
      if (n == 100 || n == 300) begin
        start = 1'b1; @(negedge clk); start = 1'b0; // R11: ignored while busy
        chk(act() == exp_at(n), "R11", act(), exp_at(n));
        idle(1);
      end else idle(2);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; idle(3);
    chk(act() == 14'd0, "R1", act(), 0);
    rst_n = 1'b1; idle(2);
    chk(act() == 14'd0, "R1", act(), 0);
  endtask

  task automatic t_ok();
    run_to_poll();
    idle(1);
    chk(phy_rst_n && pll_rst_n, "R7", {pll_rst_n, phy_rst_n}, 2'b11);
    pll_lock = 1'b1;
    tick();
    chk(done && !err && port_ctl == 2'b10, "R8", {done, err, port_ctl}, 4'b1010);
    idle(1);
    chk(!done, "R8", done, 0);
    pll_lock = 1'b0; idle(2);
  endtask

  task automatic t_lastpoll();
    run_to_poll();
    idle(2);
    for (int p = 1; p <= 7; p++) begin
      tick();
      chk(!done && pll_rst_n, "R8", {done, pll_rst_n}, 2'b01);
      pll_lock = 1'b1; @(negedge clk); pll_lock = 1'b0; // R8: off-tick lock ignored
      chk(!done, "R8", done, 0);
      idle(1);
    end
    pll_lock = 1'b1;
    tick();
    chk(done && !err && pll_rst_n, "R12", {done, err, pll_rst_n}, 3'b101);
    pll_lock = 1'b0; idle(3);
  endtask

  task automatic t_retry();
    run_to_poll();
    idle(2);
    for (int p = 1; p <= 8; p++) begin tick(); if (p < 8) idle(2); end
    chk(!pll_rst_n && phy_rst_n, "R9", {pll_rst_n, phy_rst_n}, 2'b01);
    idle(1);
    chk(pll_rst_n, "R9", pll_rst_n, 1);
    idle(1);
    for (int p = 1; p <= 3; p++) begin
      tick();
      start = 1'b1; @(negedge clk); start = 1'b0; // R11
      chk(!done && pll_rst_n && phy_rst_n && !iso, "R11", {done, pll_rst_n, phy_rst_n, iso}, 4'b0110);
      idle(1);
    end
    pll_lock = 1'b1;
    tick();
    chk(done && !err && port_ctl == 2'b10, "R9", {done, err, port_ctl}, 4'b1010);
    pll_lock = 1'b0; idle(3);
  endtask

  task automatic t_fail();
    run_to_poll();
    idle(2);
    for (int p = 1; p <= 16; p++) begin tick(); if (p < 16) idle(2); end
    chk(done && err && port_ctl == 2'b10, "R10", {done, err, port_ctl}, 4'b1110);
    idle(5);
    chk(!done && err, "R10", {done, err}, 2'b01);
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk(!err && iso, "R10", {err, iso}, 2'b01);
    for (int n = 1; n <= 25; n++) begin tick(); idle(2); end
    rst_n = 1'b0; idle(2);
    chk(act() == 14'd0, "R1", act(), 0);
    rst_n = 1'b1; idle(2);
  endtask

  initial begin
    t_reset();
    t_ok();
    t_lastpoll();
    t_retry();
    t_fail();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule